// File: doc/BRIEF.md
# Row Timing Core with Overflow and End-of-Message Interrupt

This block keeps track of which memory row a row-organised voice store is working on. While an operation is running it walks a row counter forward at a fixed row period. It also produces a row clock that is high for most of each row and low for the short tail. Fast-forward shortens the row period. The high/low split is built from separate parameters, so fast-forward may use a different duty as well. All row timing is counted in prescaled ticks, so a bench can use short periods and silicon can use the real ones.

The row counter can reach the end of the store. It can also meet a message marker while playing or skipping. In either case the block raises a flag, stops counting and pulls its active-low interrupt low. The interrupt stays low until the next serial frame begins, which a one-cycle frame-start pulse signals. A controller uses the row address, the row clock and the interrupt to manage looping or skipping. For example, on overflow it reloads address 0 and issues a new frame.

Top module: `row_clock_core`

## Requirements
- R1: After reset, `rowAddr` is 0, `rowClk` is 1, `ovfFlag` and `eomFlag` are 0 and `intN` is 1.
- R2: With `run`=1 and record (`mode`=0) or play (`mode`=1), each row lasts (NORM_HI+NORM_LO)·TICK_DIV cycles. `rowClk` is high for the first NORM_HI·TICK_DIV cycles and low for the last NORM_LO·TICK_DIV. `rowAddr` rises by one at the edge that ends the row.
- R3: In fast-forward (`mode`=2), a row lasts (FF_HI+FF_LO)·TICK_DIV cycles, with FF_HI·TICK_DIV high and FF_LO·TICK_DIV low.
- R4: While `run`=0, or while `mode`=3 (idle), the row address and the position within the row hold and `rowClk` is 1. Counting resumes from the held position.
- R5: A cycle with `loadEn`=1 sets `rowAddr` to `loadAddr` and restarts the row at its beginning. Values above ROWS-1 are clamped to ROWS-1. Load takes priority over counting.
- R6: A row that ends at address ROWS-1 sets `ovfFlag` in any running mode. The address stays at ROWS-1 and counting stops.
- R7: In play, `msgMark`=1 in the cycle a row ends sets `eomFlag`. The address is not advanced and counting stops.
- R8: In fast-forward, `msgMark`=1 in the cycle a row ends sets `eomFlag` and advances the address by one to the next message.
- R9: In record, `msgMark` has no effect: no end-of-message flag, and the address advances normally.
- R10: `intN` is 0 whenever a flag is set and stays 0 until a `frameStart` pulse. The pulse clears both flags, `intN` returns to 1 in the next cycle and counting may resume. A new event in the same cycle as the pulse wins.
- R11: When a row ends at ROWS-1 with `msgMark`=1, only `ovfFlag` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Operation running |
| mode | input | 2 | 0 record, 1 play, 2 fast-forward, 3 idle |
| loadEn | input | 1 | Load the row address this cycle |
| loadAddr | input | 12 | Row address to load |
| msgMark | input | 1 | Message marker present at the current row |
| frameStart | input | 1 | One-cycle pulse at the start of a serial frame |
| rowAddr | output | 12 | Current row |
| rowClk | output | 1 | Row clock waveform |
| ovfFlag | output | 1 | End of memory reached |
| eomFlag | output | 1 | End of message reached |
| intN | output | 1 | Active-low latched interrupt |

## Verification
The hardest situation to reach is the final row. At the real row period, the row counter takes thousands of rows to get there. The stimulus therefore loads addresses at and around ROWS-1, and sometimes above ROWS, to exercise the clamp. It pairs these loads with a marker held high, so that overflow, its priority over end-of-message, and the latched interrupt all meet at one edge. Random frame-start pulses and mode changes in mid-row then test clearing, and rows cut short by a switch to the shorter fast-forward period.

// File: rtl/row_clock_pkg.sv
package row_clock_pkg;

  typedef enum logic [1:0] {
    MODE_REC  = 2'd0,
    MODE_PLAY = 2'd1,
    MODE_FWD  = 2'd2,
    MODE_IDLE = 2'd3
  } op_mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic countEn;  // advance prescaler and row phase
    logic load;     // load row address, restart row
    logic step;     // increment row address
  } ctl_strobe_t;

endpackage

// File: rtl/row_clock_dp.sv
module row_clock_dp
  import row_clock_pkg::*;
#(
  parameter int ROWS     = 2400,
  parameter int TICK_DIV = 4,
  parameter int NORM_HI  = 14,
  parameter int NORM_LO  = 2,
  parameter int FF_HI    = 7,
  parameter int FF_LO    = 1,
  localparam int AW      = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctl_strobe_t   strobe,
  input  logic          fastMode,
  input  logic [AW-1:0] loadAddr,
  output logic [AW-1:0] rowAddr,
  output logic          rowClk,
  output logic          rowEndPend,
  output logic          atLastRow
);

  localparam int NPER = NORM_HI + NORM_LO;
  localparam int FPER = FF_HI + FF_LO;
  localparam int PMAX = (NPER > FPER) ? NPER : FPER;
  localparam int PW   = (PMAX > 1) ? $clog2(PMAX) : 1;
  localparam int TW   = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  localparam logic [PW-1:0] N_HI   = PW'(NORM_HI);
  localparam logic [PW-1:0] N_LAST = PW'(NPER - 1);
  localparam logic [PW-1:0] F_HI   = PW'(FF_HI);
  localparam logic [PW-1:0] F_LAST = PW'(FPER - 1);
  localparam logic [TW-1:0] T_LAST = TW'(TICK_DIV - 1);
  localparam logic [AW-1:0] A_LAST = AW'(ROWS - 1);

  logic [TW-1:0] tickCnt;
  logic [PW-1:0] phCnt;
  logic          tick;
  logic [PW-1:0] hiCur;
  logic [PW-1:0] lastCur;

  function automatic logic [AW-1:0] clampAddr(input logic [AW-1:0] a);
    return (a > A_LAST) ? A_LAST : a;
  endfunction

  assign tick       = (tickCnt == T_LAST);
  assign hiCur      = fastMode ? F_HI : N_HI;
  assign lastCur    = fastMode ? F_LAST : N_LAST;
  assign rowEndPend = tick && (phCnt >= lastCur);
  assign atLastRow  = (rowAddr == A_LAST);
  assign rowClk     = !strobe.countEn || (phCnt < hiCur);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
      phCnt   <= '0;
      rowAddr <= '0;
    end else if (strobe.load) begin
      tickCnt <= '0;
      phCnt   <= '0;
      rowAddr <= clampAddr(loadAddr);
    end else if (strobe.countEn) begin
      if (tick) begin
        tickCnt <= '0;
        phCnt   <= rowEndPend ? '0 : phCnt + 1'b1;
      end else begin
        tickCnt <= tickCnt + 1'b1;
      end
      if (strobe.step) rowAddr <= rowAddr + 1'b1;
    end
  end

  // R4
  hold_pos_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.countEn && !strobe.load) |=> ($stable(rowAddr) && $stable(phCnt) && $stable(tickCnt)));

  // R2
  step_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !strobe.load) |=> (rowAddr == $past(rowAddr) + 1'b1));

  // R5
  load_clamp_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (rowAddr == clampAddr($past(loadAddr)) && phCnt == '0));

endmodule

// File: rtl/row_clock_ctl.sv
module row_clock_ctl
  import row_clock_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        run,
  input  logic [1:0]  mode,
  input  logic        loadEn,
  input  logic        msgMark,
  input  logic        frameStart,
  input  logic        rowEndPend,
  input  logic        atLastRow,
  output ctl_strobe_t strobe,
  output logic        fastMode,
  output logic        ovfFlag,
  output logic        eomFlag,
  output logic        intN
);

  op_mode_e opMode;
  logic     halted;
  logic     rowDone;
  logic     markHit;
  logic     ovfSet;
  logic     eomSet;

  assign opMode   = op_mode_e'(mode);
  assign fastMode = (opMode == MODE_FWD);
  assign halted   = ovfFlag || eomFlag;
  assign markHit  = msgMark && (opMode == MODE_PLAY || opMode == MODE_FWD);

  always_comb begin
    strobe.load    = loadEn;
    strobe.countEn = run && (opMode != MODE_IDLE) && !halted && !loadEn;
    rowDone        = strobe.countEn && rowEndPend;
    ovfSet         = rowDone && atLastRow;
    eomSet         = rowDone && !atLastRow && markHit;
    strobe.step    = rowDone && !atLastRow && (!markHit || fastMode);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfFlag <= 1'b0;
      eomFlag <= 1'b0;
    end else begin
      ovfFlag <= ovfSet || (ovfFlag && !frameStart);
      eomFlag <= eomSet || (eomFlag && !frameStart);
    end
  end

  assign intN = !(ovfFlag || eomFlag);

  // R10
  int_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!intN && !frameStart) |=> !intN);

  // R10
  int_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && !rowDone) |=> intN);

  // R9
  rec_no_eom_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opMode == MODE_REC && !eomFlag) |=> !eomFlag);

endmodule

// File: rtl/row_clock_core.sv
module row_clock_core
  import row_clock_pkg::*;
#(
  parameter int ROWS     = 2400,
  parameter int TICK_DIV = 4,
  parameter int NORM_HI  = 14,
  parameter int NORM_LO  = 2,
  parameter int FF_HI    = 7,
  parameter int FF_LO    = 1,
  localparam int AW      = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          run,
  input  logic [1:0]    mode,
  input  logic          loadEn,
  input  logic [AW-1:0] loadAddr,
  input  logic          msgMark,
  input  logic          frameStart,
  output logic [AW-1:0] rowAddr,
  output logic          rowClk,
  output logic          ovfFlag,
  output logic          eomFlag,
  output logic          intN
);

  ctl_strobe_t strobe;
  logic        fastMode;
  logic        rowEndPend;
  logic        atLastRow;

  row_clock_ctl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .run        (run),
    .mode       (mode),
    .loadEn     (loadEn),
    .msgMark    (msgMark),
    .frameStart (frameStart),
    .rowEndPend (rowEndPend),
    .atLastRow  (atLastRow),
    .strobe     (strobe),
    .fastMode   (fastMode),
    .ovfFlag    (ovfFlag),
    .eomFlag    (eomFlag),
    .intN       (intN)
  );

  row_clock_dp #(
    .ROWS(ROWS), .TICK_DIV(TICK_DIV),
    .NORM_HI(NORM_HI), .NORM_LO(NORM_LO),
    .FF_HI(FF_HI), .FF_LO(FF_LO)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .fastMode   (fastMode),
    .loadAddr   (loadAddr),
    .rowAddr    (rowAddr),
    .rowClk     (rowClk),
    .rowEndPend (rowEndPend),
    .atLastRow  (atLastRow)
  );

  // R6
  ovf_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> (rowAddr == AW'(ROWS - 1)));

  // R7
  play_eom_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(eomFlag) && $past(mode) == 2'd1 && !$past(loadEn)) |-> $stable(rowAddr));

  // R8
  fwd_eom_skip_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(eomFlag) && $past(mode) == 2'd2 && !$past(loadEn)) |-> (rowAddr == $past(rowAddr) + 1'b1));

  // R11
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> !$rose(eomFlag));

endmodule

// File: tb/row_clock_core_test.sv
module row_clock_core_test;

  localparam int CLK_P    = 10;
  localparam int ROWS     = 2400;
  localparam int TICK_DIV = 4;
  localparam int NORM_HI  = 14;
  localparam int NORM_LO  = 2;
  localparam int FF_HI    = 7;
  localparam int FF_LO    = 1;
  localparam int AW       = $clog2(ROWS);
  localparam int NROW     = (NORM_HI + NORM_LO) * TICK_DIV;
  localparam int FROW     = (FF_HI + FF_LO) * TICK_DIV;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic run = 1'b0;
  logic [1:0] mode = 2'd3;
  logic loadEn = 1'b0;
  logic [AW-1:0] loadAddr = '0;
  logic msgMark = 1'b0;
  logic frameStart = 1'b0;
  logic [AW-1:0] rowAddr;
  logic rowClk, ovfFlag, eomFlag, intN;

  int nCmp = 0;
  int nBad = 0;
  string tag = "R1";

  row_clock_core uut (
    .clk(clk), .rstN(rstN), .run(run), .mode(mode), .loadEn(loadEn),
    .loadAddr(loadAddr), .msgMark(msgMark), .frameStart(frameStart),
    .rowAddr(rowAddr), .rowClk(rowClk), .ovfFlag(ovfFlag),
    .eomFlag(eomFlag), .intN(intN)
  );

  always #(CLK_P/2) clk = ~clk;

  // reference model state
  int mTick, mPh, mAddr;
  bit mOvf, mEom;

  function automatic int clampA(int a);
    return (a > ROWS - 1) ? ROWS - 1 : a;
  endfunction
  function automatic int hiOf(logic [1:0] m);
    return (m == 2'd2) ? FF_HI : NORM_HI;
  endfunction
  function automatic int lastOf(logic [1:0] m);
    return (m == 2'd2) ? FF_HI + FF_LO - 1 : NORM_HI + NORM_LO - 1;
  endfunction
  function automatic bit enOf();
    return run && mode != 2'd3 && !(mOvf || mEom) && !loadEn;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mTick = 0; mPh = 0; mAddr = 0; mOvf = 0; mEom = 0;
    end else begin
      bit en, rowEnd, ovfEv, eomEv;
      en = enOf(); rowEnd = 0; ovfEv = 0; eomEv = 0;
      if (loadEn) begin
        mAddr = clampA(int'(loadAddr)); mTick = 0; mPh = 0;
      end else if (en) begin
        rowEnd = (mTick == TICK_DIV - 1) && (mPh >= lastOf(mode));
        if (mTick == TICK_DIV - 1) begin
          mTick = 0;
          mPh = rowEnd ? 0 : mPh + 1;
        end else mTick++;
        if (rowEnd) begin
          if (mAddr == ROWS - 1) ovfEv = 1;
          else if (msgMark && (mode == 2'd1 || mode == 2'd2)) begin
            eomEv = 1;
            if (mode == 2'd2) mAddr++;
          end else mAddr++;
        end
      end
      mOvf = ovfEv || (mOvf && !frameStart);
      mEom = eomEv || (mEom && !frameStart);
    end
  end

  task automatic chk(string t, int got, int exp, string what);
    nCmp++;
    if (got != exp) begin
      nBad++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", t, what, got, exp, $time);
    end
  endtask

  task automatic cmpAll();
    chk(tag, int'(rowAddr), mAddr, "rowAddr");
    chk(tag, int'(rowClk), int'(!enOf() || mPh < hiOf(mode)), "rowClk");
    chk(tag, int'(ovfFlag), int'(mOvf), "ovfFlag");
    chk(tag, int'(eomFlag), int'(mEom), "eomFlag");
    chk(tag, int'(intN), int'(!(mOvf || mEom)), "intN");
  endtask

  // one clock: compare after the edge, then leave inputs for the next edge
  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #(CLK_P/4);
      cmpAll();
    end
  endtask

  task automatic doLoad(int a);
    loadEn = 1'b1; loadAddr = AW'(a);
    cyc(1);
    loadEn = 1'b0;
  endtask

  task automatic pulseFrame();
    frameStart = 1'b1; cyc(1); frameStart = 1'b0;
  endtask

  initial begin
    #(CLK_P * 100000);
    nBad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5eed));
    #(CLK_P * 3 + 2);
    // R1 reset state
    tag = "R1";
    chk("R1", int'(rowAddr), 0, "rowAddr");
    chk("R1", int'(rowClk), 1, "rowClk");
    chk("R1", int'(intN), 1, "intN");
    rstN = 1'b1;
    cyc(3);

    // R2 normal row timing
    tag = "R2"; mode = 2'd1; run = 1'b1;
    doLoad(10);
    cyc(NORM_HI * TICK_DIV - 1);
    chk("R2", int'(rowClk), 1, "rowClk end of high");
    cyc(1);
    chk("R2", int'(rowClk), 0, "rowClk low");
    cyc(NORM_LO * TICK_DIV);
    chk("R2", int'(rowAddr), 11, "rowAddr after row");

    // R3 fast-forward row timing
    tag = "R3"; mode = 2'd2;
    doLoad(20);
    cyc(FF_HI * TICK_DIV);
    chk("R3", int'(rowClk), 0, "rowClk low");
    cyc(FF_LO * TICK_DIV);
    chk("R3", int'(rowAddr), 21, "rowAddr after row");

    // R4 hold while stopped
    tag = "R4"; run = 1'b0;
    cyc(50);
    chk("R4", int'(rowAddr), 21, "rowAddr held");
    chk("R4", int'(rowClk), 1, "rowClk idle");
    run = 1'b1; mode = 2'd3;
    cyc(40);
    chk("R4", int'(rowAddr), 21, "rowAddr idle mode");

    // R7 end of message in play
    tag = "R7"; mode = 2'd1; msgMark = 1'b1;
    doLoad(30);
    cyc(NROW);
    chk("R7", int'(eomFlag), 1, "eomFlag");
    chk("R7", int'(rowAddr), 30, "rowAddr held");
    cyc(30);
    // R10 latched until frame start
    tag = "R10";
    chk("R10", int'(intN), 0, "intN latched");
    msgMark = 1'b0;
    pulseFrame();
    chk("R10", int'(intN), 1, "intN after frame");

    // R8 fast-forward skip
    tag = "R8"; mode = 2'd2; msgMark = 1'b1;
    doLoad(40);
    cyc(FROW);
    chk("R8", int'(eomFlag), 1, "eomFlag");
    chk("R8", int'(rowAddr), 41, "rowAddr skipped");
    msgMark = 1'b0; pulseFrame();

    // R9 marker ignored while recording
    tag = "R9"; mode = 2'd0; msgMark = 1'b1;
    doLoad(50);
    cyc(NROW);
    chk("R9", int'(eomFlag), 0, "eomFlag");
    chk("R9", int'(rowAddr), 51, "rowAddr");

    // R6 / R11 overflow at last row with marker
    tag = "R11"; mode = 2'd1;
    doLoad(ROWS - 1);
    cyc(NROW);
    chk("R6", int'(ovfFlag), 1, "ovfFlag");
    chk("R11", int'(eomFlag), 0, "eomFlag");
    chk("R6", int'(rowAddr), ROWS - 1, "rowAddr");
    msgMark = 1'b0; pulseFrame();

    // R5 clamp
    tag = "R5";
    doLoad((1 << AW) - 1);
    chk("R5", int'(rowAddr), ROWS - 1, "clamped");

    // random mix
    tag = "R10 random";
    for (int s = 0; s < 60; s++) begin
      for (int c = 0; c < 150; c++) begin
        run = ($urandom_range(0, 9) != 0);
        if ($urandom_range(0, 63) == 0) mode = 2'($urandom_range(0, 3));
        msgMark = ($urandom_range(0, 39) == 0);
        frameStart = ($urandom_range(0, 59) == 0);
        loadEn = ($urandom_range(0, 299) == 0);
        loadAddr = ($urandom_range(0, 1) != 0) ? AW'($urandom_range(ROWS - 3, (1 << AW) - 1))
                                               : AW'($urandom_range(0, ROWS - 1));
        cyc(1);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule